// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Hardware Table Walk

This block turns a 16-bit virtual address into a 16-bit physical address. The upper byte is the virtual page number and the lower byte is the offset within the page. A small fully associative cache of recent translations answers most requests on the cycle after they are accepted. Each cached translation carries a write-permission bit, a modified (dirty) bit and a usage bit along with the physical page number.

When the cache misses, the block walks a flat page table held in memory. It first compares the page number with a table-size limit and rejects out-of-range pages without touching memory. Otherwise it reads one table word from the table base address plus the page number. An absent entry ends the request as a page fault. A present entry is copied into the cache and the address is translated. Cache slots are refilled in round-robin order.

Every accepted request ends with exactly one response. The response carries a status code, the translated address, and the modified state of the page after the access.

Top module: `tlb_walk_unit`

## Requirements
- R1: On a successful translation `resp_paddr` is the 8-bit physical page number in bits [15:8], with bits [7:0] equal to the request's offset bits [7:0].
- R2: A request that hits a cached translation responds on the cycle after acceptance with status 0 (success) and makes no table read.
- R3: On a miss with an in-range page, the block raises `mem_req` with `mem_addr` = `pt_base` + page number and holds both until `mem_rvalid`. It responds on the cycle after `mem_rvalid`. A table word has bit 15 = present, bit 14 = writable and bits [7:0] = physical page number.
- R4: On a miss whose page number is at or above `pt_limit`, the block responds on the next cycle with status 1 (bounds error) and makes no table read.
- R5: A table word with the present bit clear gives status 2 (page fault) and is not cached, so a repeat of the same page walks the table again.
- R6: A present table word is written into the cache, and later accesses to that page hit without a table read.
- R7: A write to a page whose writable bit is clear gives status 3 (protection error), whether the page hits or is walked. A read of the same page succeeds.
- R8: `resp_dirty` reports the page's modified bit after the access. A successful write sets it, both on a hit and on a walk. Later reads keep it. Failed writes leave it unchanged.
- R9: Cache fills use slots in round-robin order over the 8 slots, so the ninth fill after reset evicts the first page filled.
- R10: Each accepted request produces exactly one one-cycle `resp_valid`. `req_ready` is low during a walk. Any error status returns `resp_paddr` = 0.
- R11: During reset `resp_valid` and `mem_req` are low. After reset the cache holds no translation, and `req_ready` is high by the third clock after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 16 | Virtual address: page number [15:8], offset [7:0] |
| req_write | input | 1 | Request is a write access |
| pt_base | input | 16 | Memory address of table entry for page 0 |
| pt_limit | input | 9 | Number of pages covered by the table |
| mem_req | output | 1 | Table read request, held until data returns |
| mem_addr | output | 16 | Table word address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 16 | Table word |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_paddr | output | 16 | Physical address (0 on error) |
| resp_status | output | 2 | 0 success, 1 bounds, 2 page fault, 3 protection |
| resp_dirty | output | 1 | Modified bit of the page after the access |

## Verification
The assertions assume that `pt_base` and `pt_limit` stay constant while the cache holds entries. If the limit were lowered, a cached page above it would still hit, and the bounds check would not apply to it. They also assume that memory raises `mem_rvalid` only while `mem_req` is high. The stimulus sets the table registers once, before reset release. The bench's table model answers a read only in the cycle after it sees `mem_req` and never answers twice for one request.

// File: rtl/tlb_walk_pkg.sv
package tlb_walk_pkg;
  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_BOUNDS = 2'd1,
    ST_FAULT  = 2'd2,
    ST_PROT   = 2'd3
  } xlat_status_e;

  typedef enum logic {
    S_IDLE  = 1'b0,
    S_FETCH = 1'b1
  } walk_state_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 8,
  parameter int PPN_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_wr_ok,
  output logic             lk_dirty,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr_ok,
  input  logic             fill_dirty,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_set_dirty
);
  logic [ENTRIES-1:0] valid_q, wr_q, dirty_q, used_q, match;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q, ptr_n;
  logic               unused_usage;

  assign unused_usage = ^used_q;

  // replacement pointer: next-state then register
  always_comb begin
    ptr_n = ptr_q;
    if (fill_en) ptr_n = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic ld, tch;
    assign ld       = fill_en && (ptr_q == IDX_W'(i));
    assign tch      = touch_en && (touch_idx == IDX_W'(i));
    assign match[i] = valid_q[i] && (vpn_q[i] == lk_vpn);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  valid_q[i] <= 1'b0;
      else if (ld) valid_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (ld) begin
        vpn_q[i] <= fill_vpn;
        ppn_q[i] <= fill_ppn;
        wr_q[i]  <= fill_wr_ok;
      end
    end

    always_ff @(posedge clk) begin
      if (ld) begin
        dirty_q[i] <= fill_dirty;
        used_q[i]  <= 1'b1;
      end else if (tch) begin
        dirty_q[i] <= dirty_q[i] | touch_set_dirty;
        used_q[i]  <= 1'b1;
      end
    end
  end

  always_comb begin
    lk_hit   = |match;
    lk_idx   = '0;
    lk_ppn   = '0;
    lk_wr_ok = 1'b0;
    lk_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_idx   = IDX_W'(i);
        lk_ppn   = ppn_q[i];
        lk_wr_ok = wr_q[i];
        lk_dirty = dirty_q[i];
      end
    end
  end
endmodule

// File: rtl/tlb_walk_ctl.sv
module tlb_walk_ctl
  import tlb_walk_pkg::*;
#(
  parameter int VPN_W   = 8,
  parameter int OFF_W   = 8,
  parameter int PPN_W   = 8,
  parameter int ENTRIES = 8,
  parameter int MEM_AW  = 16,
  parameter int PTE_W   = 16,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic [MEM_AW-1:0] pt_base,
  input  logic [VPN_W:0]    pt_limit,
  input  logic              lk_hit,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [PPN_W-1:0]  lk_ppn,
  input  logic              lk_wr_ok,
  input  logic              lk_dirty,
  output logic              fill_en,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [PPN_W-1:0]  fill_ppn,
  output logic              fill_wr_ok,
  output logic              fill_dirty,
  output logic              touch_en,
  output logic [IDX_W-1:0]  touch_idx,
  output logic              touch_set_dirty,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata,
  output logic              resp_valid,
  output logic [PA_W-1:0]   resp_paddr,
  output logic [1:0]        resp_status,
  output logic              resp_dirty
);
  localparam int PRESENT_BIT = PTE_W - 1;
  localparam int WRITE_BIT   = PTE_W - 2;

  walk_state_e      state_q, state_n;
  logic [VPN_W-1:0] cur_vpn_q, req_vpn;
  logic [OFF_W-1:0] cur_off_q, req_off;
  logic             cur_wr_q, cur_ld;
  logic             rsp_v_n, rsp_d_n;
  logic [PA_W-1:0]  rsp_pa_n;
  xlat_status_e     rsp_st_n;
  logic             pte_present, pte_wr;
  logic [PPN_W-1:0] pte_ppn;
  logic             unused_pte_bits;

  assign req_vpn         = req_vaddr[VA_W-1:OFF_W];
  assign req_off         = req_vaddr[OFF_W-1:0];
  assign pte_present     = mem_rdata[PRESENT_BIT];
  assign pte_wr          = mem_rdata[WRITE_BIT];
  assign pte_ppn         = mem_rdata[PPN_W-1:0];
  assign unused_pte_bits = ^mem_rdata[PTE_W-3:PPN_W];

  assign req_ready  = (state_q == S_IDLE) && rst_n;
  assign mem_req    = (state_q == S_FETCH);
  assign mem_addr   = pt_base + MEM_AW'(cur_vpn_q);
  assign fill_vpn   = cur_vpn_q;
  assign fill_ppn   = pte_ppn;
  assign fill_wr_ok = pte_wr;
  assign touch_idx  = lk_idx;

  always_comb begin
    state_n         = state_q;
    cur_ld          = 1'b0;
    rsp_v_n         = 1'b0;
    rsp_pa_n        = '0;
    rsp_st_n        = ST_OK;
    rsp_d_n         = 1'b0;
    fill_en         = 1'b0;
    fill_dirty      = 1'b0;
    touch_en        = 1'b0;
    touch_set_dirty = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          if (lk_hit) begin
            rsp_v_n  = 1'b1;
            touch_en = 1'b1;
            if (req_write && !lk_wr_ok) begin
              rsp_st_n = ST_PROT;
              rsp_d_n  = lk_dirty;
            end else begin
              rsp_pa_n        = {lk_ppn, req_off};
              rsp_d_n         = lk_dirty | req_write;
              touch_set_dirty = req_write;
            end
          end else if ({1'b0, req_vpn} >= pt_limit) begin
            rsp_v_n  = 1'b1;
            rsp_st_n = ST_BOUNDS;
          end else begin
            cur_ld  = 1'b1;
            state_n = S_FETCH;
          end
        end
      end
      S_FETCH: begin
        if (mem_rvalid) begin
          state_n = S_IDLE;
          rsp_v_n = 1'b1;
          if (!pte_present) begin
            rsp_st_n = ST_FAULT;
          end else begin
            fill_en    = 1'b1;
            fill_dirty = cur_wr_q && pte_wr;
            rsp_d_n    = cur_wr_q && pte_wr;
            if (cur_wr_q && !pte_wr) rsp_st_n = ST_PROT;
            else                     rsp_pa_n = {pte_ppn, cur_off_q};
          end
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      resp_valid <= 1'b0;
    end else begin
      state_q    <= state_n;
      resp_valid <= rsp_v_n;
    end
  end

  always_ff @(posedge clk) begin
    resp_paddr  <= rsp_pa_n;
    resp_status <= rsp_st_n;
    resp_dirty  <= rsp_d_n;
  end

  always_ff @(posedge clk) begin
    if (cur_ld) begin
      cur_vpn_q <= req_vpn;
      cur_off_q <= req_off;
      cur_wr_q  <= req_write;
    end
  end
endmodule

// File: rtl/tlb_walk_unit.sv
module tlb_walk_unit #(
  parameter int VPN_W   = 8,
  parameter int OFF_W   = 8,
  parameter int PPN_W   = 8,
  parameter int ENTRIES = 8,
  parameter int MEM_AW  = 16,
  parameter int PTE_W   = 16,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic [MEM_AW-1:0] pt_base,
  input  logic [VPN_W:0]    pt_limit,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata,
  output logic              resp_valid,
  output logic [PA_W-1:0]   resp_paddr,
  output logic [1:0]        resp_status,
  output logic              resp_dirty
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             lk_hit, lk_wr_ok, lk_dirty;
  logic [IDX_W-1:0] lk_idx, touch_idx;
  logic [PPN_W-1:0] lk_ppn, fill_ppn;
  logic [VPN_W-1:0] fill_vpn;
  logic             fill_en, fill_wr_ok, fill_dirty;
  logic             touch_en, touch_set_dirty;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
    .clk(clk), .rst_n(rst_int_n),
    .lk_vpn(req_vaddr[VA_W-1:OFF_W]), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_ppn(lk_ppn), .lk_wr_ok(lk_wr_ok), .lk_dirty(lk_dirty),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_wr_ok(fill_wr_ok), .fill_dirty(fill_dirty),
    .touch_en(touch_en), .touch_idx(touch_idx), .touch_set_dirty(touch_set_dirty)
  );

  tlb_walk_ctl #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES),
                 .MEM_AW(MEM_AW), .PTE_W(PTE_W)) u_ctl (
    .clk(clk), .rst_n(rst_int_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .pt_base(pt_base), .pt_limit(pt_limit),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_wr_ok(lk_wr_ok),
    .lk_dirty(lk_dirty),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_wr_ok(fill_wr_ok), .fill_dirty(fill_dirty),
    .touch_en(touch_en), .touch_idx(touch_idx), .touch_set_dirty(touch_set_dirty),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_status(resp_status), .resp_dirty(resp_dirty)
  );
endmodule

// File: rtl/tlb_walk_chk.sv
module tlb_walk_chk #(
  parameter int VPN_W  = 8,
  parameter int OFF_W  = 8,
  parameter int PPN_W  = 8,
  parameter int MEM_AW = 16,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic [VPN_W:0]    pt_limit,
  input logic              mem_req,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              resp_valid,
  input logic [PA_W-1:0]   resp_paddr,
  input logic [1:0]        resp_status
);
  logic             fire, pend_q;
  logic [OFF_W-1:0] last_off_q;

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (fire)       pend_q <= 1'b1;
    else if (resp_valid) pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (fire) last_off_q <= req_vaddr[OFF_W-1:0];
  end

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status == 2'd0) |-> resp_paddr[OFF_W-1:0] == last_off_q);

  // R3
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R4
  bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ({1'b0, req_vaddr[VA_W-1:OFF_W]} >= pt_limit))
      |=> (resp_valid && resp_status == 2'd1 && !mem_req));

  // R10
  one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> pend_q);

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (!pend_q || resp_valid));

  // R10
  busy_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status != 2'd0) |-> resp_paddr == '0);
endmodule

bind tlb_walk_unit tlb_walk_chk #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W),
                                  .MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .pt_limit(pt_limit), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .resp_valid(resp_valid),
  .resp_paddr(resp_paddr), .resp_status(resp_status)
);

// File: tb/tb_tlb_walk_unit.sv
module tb_tlb_walk_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PT_BASE  = 16'h4000;
  localparam logic [8:0]  PT_LIMIT = 9'h080;
  localparam int NVEC = 13;
  // {vaddr, write, status, paddr, dirty, walked}
  localparam logic [36:0] VEC [NVEC] = '{
    {16'h0312, 1'b0, 2'd0, 16'hA612, 1'b0, 1'b1},
    {16'h03FF, 1'b0, 2'd0, 16'hA6FF, 1'b0, 1'b0},
    {16'h0301, 1'b1, 2'd0, 16'hA601, 1'b1, 1'b0},
    {16'h0300, 1'b0, 2'd0, 16'hA600, 1'b1, 1'b0},
    {16'h4122, 1'b1, 2'd3, 16'h0000, 1'b0, 1'b1},
    {16'h4122, 1'b0, 2'd0, 16'hE422, 1'b0, 1'b0},
    {16'h4100, 1'b1, 2'd3, 16'h0000, 1'b0, 1'b0},
    {16'h0F10, 1'b0, 2'd2, 16'h0000, 1'b0, 1'b1},
    {16'h0F10, 1'b0, 2'd2, 16'h0000, 1'b0, 1'b1},
    {16'h8000, 1'b0, 2'd1, 16'h0000, 1'b0, 1'b0},
    {16'hFF55, 1'b1, 2'd1, 16'h0000, 1'b0, 1'b0},
    {16'h2E33, 1'b1, 2'd0, 16'h8B33, 1'b1, 1'b1},
    {16'h7E9C, 1'b0, 2'd0, 16'hDB9C, 1'b0, 1'b1}
  };

  logic clk, rst_n, req_valid, req_ready, req_write;
  logic [15:0] req_vaddr, mem_addr, mem_rdata, resp_paddr;
  logic mem_req, mem_rvalid, resp_valid, resp_dirty;
  logic [1:0] resp_status;
  int checks, errors, mem_reads;
  bit done;

  logic [1:0]  r_status;
  logic [15:0] r_paddr, r_maddr;
  logic r_dirty, r_rdy_mid, r_extra;
  int r_reads;

  tlb_walk_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .pt_base(PT_BASE),
    .pt_limit(PT_LIMIT), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
    .resp_paddr(resp_paddr), .resp_status(resp_status), .resp_dirty(resp_dirty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // table model: absent when low nibble is F, read-only when bit 6 set, ppn = vpn ^ A5
  function automatic logic [15:0] pte_of(input logic [15:0] addr);
    logic [7:0] v;
    v = 8'(addr - PT_BASE);
    return {v[3:0] != 4'hF, !v[6], 6'b0, v ^ 8'hA5};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_req && !mem_rvalid;
      mem_rdata  <= pte_of(mem_addr);
      if (mem_req && mem_rvalid) mem_reads <= mem_reads + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [15:0] va, input logic wr);
    int n, start;
    start = mem_reads;
    @(negedge clk);
    req_vaddr = va;
    req_write = wr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    r_rdy_mid = req_ready;
    r_maddr   = mem_addr;
    n = 0;
    while (!resp_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    r_status = resp_status;
    r_paddr  = resp_paddr;
    r_dirty  = resp_dirty;
    r_reads  = mem_reads - start;
    @(negedge clk);
    r_extra = resp_valid;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(resp_valid == 1'b0, "R11", "resp_valid in reset", 32'(resp_valid), 0);
    chk(mem_req == 1'b0, "R11", "mem_req in reset", 32'(mem_req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "req_ready after release", 32'(req_ready), 1);
  endtask

  function automatic string tag_of(input logic [1:0] st, input logic walked);
    case (st)
      2'd0:    return walked ? "R3" : "R2";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R7";
    endcase
  endfunction

  initial begin
    checks = 0; errors = 0; mem_reads = 0; done = 0;
    rst_n = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
    #1 rst_n = 1'b0;
    do_reset();

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] va, pa;
      logic wr, dr, wk;
      logic [1:0] st;
      {va, wr, st, pa, dr, wk} = VEC[i];
      do_req(va, wr);
      chk(r_status == st, tag_of(st, wk), $sformatf("status vec %0d", i), 32'(r_status), 32'(st));
      chk(r_paddr == pa, (st == 2'd0) ? "R1" : "R10", $sformatf("paddr vec %0d", i), 32'(r_paddr), 32'(pa));
      chk(r_dirty == dr, "R8", $sformatf("dirty vec %0d", i), 32'(r_dirty), 32'(dr));
      chk(r_reads == int'(wk), wk ? "R6" : "R2", $sformatf("table reads vec %0d", i), 32'(r_reads), 32'(wk));
      chk(r_extra == 1'b0, "R10", $sformatf("single response vec %0d", i), 32'(r_extra), 0);
      if (wk) begin
        chk(r_maddr == PT_BASE + {8'h00, va[15:8]}, "R3", $sformatf("table address vec %0d", i), 32'(r_maddr), 32'(PT_BASE + {8'h00, va[15:8]}));
        chk(r_rdy_mid == 1'b0, "R10", $sformatf("ready during walk vec %0d", i), 32'(r_rdy_mid), 0);
      end
    end

    // R9: slots 0..3 hold 03,41,2E,7E; fill four more, then a fifth evicts page 03
    for (int p = 16; p < 21; p++) begin
      do_req({8'(p), 8'h00}, 1'b0);
      chk(r_reads == 1, "R9", $sformatf("fill page %0h", p), 32'(r_reads), 1);
    end
    do_req(16'h4101, 1'b0);
    chk(r_reads == 0 && r_paddr == 16'hE401, "R9", "page 41 still cached", 32'(r_reads), 0);
    do_req(16'h0305, 1'b0);
    chk(r_reads == 1, "R9", "oldest page 03 evicted", 32'(r_reads), 1);
    chk(r_paddr == 16'hA605, "R1", "refetched page 03 address", 32'(r_paddr), 32'hA605);
    do_req(16'h4101, 1'b0);
    chk(r_reads == 1, "R9", "page 41 evicted by next fill", 32'(r_reads), 1);

    // R11: reset empties the cache
    do_reset();
    do_req(16'h2E33, 1'b0);
    chk(r_reads == 1, "R11", "cache empty after reset", 32'(r_reads), 1);
    chk(r_dirty == 1'b0, "R8", "fresh read fill clean", 32'(r_dirty), 0);
    do_req(16'h7F00, 1'b0);
    chk(r_status == 2'd2 && r_reads == 1, "R4", "page limit-1 is in range", 32'(r_status), 2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule